// File: doc/BRIEF.md
# Dual-Sink Hot-Plug Selection Arbiter

This block decides which of two downstream displays, a DisplayPort sink or an HDMI/DVI sink, is connected to a single upstream video source. It samples the two sink hot-plug levels, a cable-adapter-detect level and a priority strap through synchronizers and a debounce filter. A small state machine then picks one sink and drives a one-hot route select that steers the main link together with AUX (DisplayPort side) or DDC (HDMI/DVI side).

Toward the source the block drives a hot-plug output and a cable-adapter output. When the priority strap moves the selection from one connected sink to the other, the source hot-plug line drops low for a programmable number of clock cycles, so the source re-reads the new display. The new route is applied at the first cycle of that low pulse. Register bits supplied from outside set the cable-adapter polarity, a compliance override and the length of the pulse. A block enable works as a soft reset: it idles the routes and masks the register bits, but the input filters keep running.

Top module: `hpd_arbiter`

## Requirements
- R1: Each of `dp_hpd_in`, `tmds_hpd_in`, `cad_in` and `prio_tmds` passes through SYNC_STAGES flops and a debounce filter that takes a new level only after it has been stable for DEB_CYCLES cycles. With the defaults (2, 4), a change on a hot-plug input from idle shows on `route` after exactly 7 rising edges and not after 6. A pulse shorter than DEB_CYCLES cycles has no effect.
- R2: With compliance mode off, `src_hpd` is high while a sink is selected and no switchover pulse is running. It is low when no sink is selected.
- R3: When both sinks are present, `prio_tmds` low selects the DisplayPort sink (`route` = 2'b01) and `prio_tmds` high selects the HDMI/DVI sink (`route` = 2'b10).
- R4: When exactly one sink is present, that sink is selected. When no sink is present, `route` is 2'b00.
- R5: `route` never has more than one bit set. During a switchover it shows the new sink from the first low cycle of `src_hpd`.
- R6: A change of selection caused by priority while both sinks stay present drives `src_hpd` low for exactly `swap_len` cycles, or 1 cycle when `swap_len` is 0. A change caused by unplugging the selected sink produces no low pulse.
- R7: `cad_src` equals the filtered `cad_in` XOR `cad_invert` while the DisplayPort sink is routed. It is 1 while the HDMI/DVI sink is routed and 0 when idle.
- R8: `dp_tmds_mode` is high only while the DisplayPort sink is routed and the filtered `cad_in` is high (dual-mode TMDS). A low `cad_in` means native DisplayPort.
- R9: While `en` is low, `route`, `src_hpd`, `cad_src` and `dp_tmds_mode` are 0, and `cad_invert` and `comp_mode` act as their default value 0. The input filters keep running, so a sink that is already present is routed one rising edge after `en` rises.
- R10: With `comp_mode` high, `comp_dp_hpd` replaces the filtered DisplayPort hot-plug level and takes effect at the next edge, and `src_hpd` follows `comp_src_hpd` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low idles routes and masks register bits |
| dp_hpd_in | input | 1 | Hot-plug level from the DisplayPort sink |
| tmds_hpd_in | input | 1 | Hot-plug level from the HDMI/DVI sink |
| cad_in | input | 1 | Cable-adapter-detect level from the DisplayPort connector |
| prio_tmds | input | 1 | Priority strap: 1 favours the HDMI/DVI sink |
| cad_invert | input | 1 | Register bit: invert `cad_src` when the DisplayPort sink is routed |
| comp_mode | input | 1 | Register bit: compliance override enable |
| comp_dp_hpd | input | 1 | Register bit: DisplayPort hot-plug value used in compliance mode |
| comp_src_hpd | input | 1 | Register bit: source hot-plug value in compliance mode |
| swap_len | input | PULSE_W | Register field: switchover low-pulse length in cycles |
| src_hpd | output | 1 | Hot-plug output to the source |
| cad_src | output | 1 | Cable-adapter output to the source |
| route | output | 2 | One-hot route select: bit 0 DisplayPort path, bit 1 HDMI/DVI path |
| dp_tmds_mode | output | 1 | DisplayPort sink running in dual-mode TMDS |

## Verification
A sink input change reaches the selection after SYNC_STAGES + DEB_CYCLES + 1 rising edges, which is 7 with the defaults. The cable-adapter path reaches `cad_src` one edge earlier, because that output is formed from the filtered level without passing through the state register. The register bits `cad_invert`, `comp_src_hpd` and `en` act on the outputs within the same cycle, and `comp_dp_hpd` acts one edge later. The bench drives all inputs on falling edges and samples on falling edges. The latency is checked exactly on both sides of edge 7. Random stimulus holds each input pattern for 30 cycles, which covers the filter delay plus the longest switchover pulse, before it compares against the expected steady state. Pulse lengths are found by counting low samples of `src_hpd` over a fixed window.

// File: rtl/hpd_arb_pkg.sv
package hpd_arb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DP   = 2'd1,
      ST_TM   = 2'd2,
      ST_SWAP = 2'd3
   } arb_state_t;

   localparam int ROUTE_W   = 2;
   localparam int ROUTE_DP  = 0;
   localparam int ROUTE_TM  = 1;

   // Desired sink from presence levels and priority strap
   function automatic arb_state_t pick_sink(input logic dp_here,
                                            input logic tm_here,
                                            input logic tm_first);
      if (dp_here && tm_here) return tm_first ? ST_TM : ST_DP;
      if (dp_here)            return ST_DP;
      if (tm_here)            return ST_TM;
      return ST_IDLE;
   endfunction

endpackage

// File: rtl/hpd_sync_deb.sv
module hpd_sync_deb #(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

   generate
      if (WIDTH < 1)       begin : g_bad_w  $error("WIDTH must be at least 1");       end
      if (SYNC_STAGES < 2) begin : g_bad_s  $error("SYNC_STAGES must be at least 2"); end
      if (DEB_CYCLES < 1)  begin : g_bad_d  $error("DEB_CYCLES must be at least 1");  end
   endgenerate

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [SYNC_STAGES-1:0] chain;
      logic                   synced;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], din[i]};
      end
      assign synced = chain[SYNC_STAGES-1];

      if (DEB_CYCLES == 1) begin : g_nofilt
         logic held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= 1'b0;
            else        held <= synced;
         end
         assign dout[i] = held;
      end else begin : g_filt
         logic          held;
         logic [CW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held <= 1'b0;
               run  <= '0;
            end else if (synced != held) begin
               if (run == CW'(DEB_CYCLES - 1)) begin
                  held <= synced;
                  run  <= '0;
               end else begin
                  run  <= run + 1'b1;
               end
            end else begin
               run <= '0;
            end
         end
         assign dout[i] = held;
      end
   end

endmodule

// File: rtl/hpd_sel_fsm.sv
module hpd_sel_fsm
   import hpd_arb_pkg::*;
#(
   parameter int PULSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               dp_here,
   input  logic               tm_here,
   input  logic               tm_first,
   input  logic [PULSE_W-1:0] swap_len,
   output arb_state_t         state,
   output logic               swap_to_tm
);

   generate
      if (PULSE_W < 1) begin : g_bad_pw $error("PULSE_W must be at least 1"); end
   endgenerate

   arb_state_t         want;
   logic [PULSE_W-1:0] left;
   logic [PULSE_W-1:0] load;

   assign want = pick_sink(dp_here, tm_here, tm_first);
   assign load = (swap_len == '0) ? '0 : swap_len - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         swap_to_tm <= 1'b0;
         left       <= '0;
      end else if (!en) begin
         state      <= ST_IDLE;
         swap_to_tm <= 1'b0;
         left       <= '0;
      end else begin
         unique case (state)
            ST_IDLE: state <= want;
            ST_DP: begin
               if (want == ST_TM) begin
                  if (dp_here) begin
                     state      <= ST_SWAP;
                     swap_to_tm <= 1'b1;
                     left       <= load;
                  end else begin
                     state <= ST_TM;
                  end
               end else if (want == ST_IDLE) begin
                  state <= ST_IDLE;
               end
            end
            ST_TM: begin
               if (want == ST_DP) begin
                  if (tm_here) begin
                     state      <= ST_SWAP;
                     swap_to_tm <= 1'b0;
                     left       <= load;
                  end else begin
                     state <= ST_DP;
                  end
               end else if (want == ST_IDLE) begin
                  state <= ST_IDLE;
               end
            end
            ST_SWAP: begin
               if (left == '0) state <= swap_to_tm ? ST_TM : ST_DP;
               else            left  <= left - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hpd_arbiter.sv
module hpd_arbiter
   import hpd_arb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4,
   parameter int PULSE_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               dp_hpd_in,
   input  logic               tmds_hpd_in,
   input  logic               cad_in,
   input  logic               prio_tmds,
   input  logic               cad_invert,
   input  logic               comp_mode,
   input  logic               comp_dp_hpd,
   input  logic               comp_src_hpd,
   input  logic [PULSE_W-1:0] swap_len,
   output logic               src_hpd,
   output logic               cad_src,
   output logic [1:0]         route,
   output logic               dp_tmds_mode
);

   localparam int NIN     = 4;
   localparam int I_DP    = 0;
   localparam int I_TM    = 1;
   localparam int I_CAD   = 2;
   localparam int I_PRIO  = 3;

   logic [NIN-1:0] raw_in;
   logic [NIN-1:0] filt;
   arb_state_t     state;
   logic           swap_to_tm;
   logic           inv_eff;
   logic           comp_eff;
   logic           dp_eff;
   logic           dp_side;
   logic           tm_side;
   logic           linked;

   assign raw_in = {prio_tmds, cad_in, tmds_hpd_in, dp_hpd_in};

   hpd_sync_deb #(
      .WIDTH      (NIN),
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
   ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (filt)
   );

   // Register bits fall back to defaults while disabled
   assign inv_eff  = en & cad_invert;
   assign comp_eff = en & comp_mode;
   assign dp_eff   = comp_eff ? comp_dp_hpd : filt[I_DP];

   hpd_sel_fsm #(.PULSE_W(PULSE_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .dp_here   (dp_eff),
      .tm_here   (filt[I_TM]),
      .tm_first  (filt[I_PRIO]),
      .swap_len  (swap_len),
      .state     (state),
      .swap_to_tm(swap_to_tm)
   );

   assign dp_side = en & ((state == ST_DP) | ((state == ST_SWAP) & ~swap_to_tm));
   assign tm_side = en & ((state == ST_TM) | ((state == ST_SWAP) &  swap_to_tm));
   assign linked  = (state == ST_DP) | (state == ST_TM);

   always_comb begin
      route           = '0;
      route[ROUTE_DP] = dp_side;
      route[ROUTE_TM] = tm_side;
   end

   assign src_hpd      = ~en ? 1'b0 : (comp_eff ? comp_src_hpd : linked);
   assign cad_src      = dp_side ? (filt[I_CAD] ^ inv_eff) : tm_side;
   assign dp_tmds_mode = dp_side & filt[I_CAD];

endmodule

// File: rtl/hpd_arbiter_chk.sv
module hpd_arbiter_chk #(
   parameter int PULSE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic               dp_hpd_in,
   input logic               tmds_hpd_in,
   input logic               cad_in,
   input logic               prio_tmds,
   input logic               cad_invert,
   input logic               comp_mode,
   input logic               comp_dp_hpd,
   input logic               comp_src_hpd,
   input logic [PULSE_W-1:0] swap_len,
   input logic               src_hpd,
   input logic               cad_src,
   input logic [1:0]         route,
   input logic               dp_tmds_mode
);

   assert_route_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route));

   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (route == 2'b00) && !src_hpd && !cad_src && !dp_tmds_mode);

   assert_hdmi_cad_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (route == 2'b10) |-> cad_src);

   assert_idle_cad_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (route == 2'b00) |-> !cad_src);

   assert_mode_flag_dp_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dp_tmds_mode |-> (route == 2'b01));

   assert_no_sink_no_hpd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !comp_mode && route == 2'b00) |-> !src_hpd);

   assert_swap_drops_hpd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !comp_mode && $past(en) && route != 2'b00 && $past(route) != 2'b00
       && route != $past(route) && $past(tmds_hpd_in) && $past(dp_hpd_in))
      |-> !src_hpd);

endmodule

bind hpd_arbiter hpd_arbiter_chk #(.PULSE_W(PULSE_W)) u_chk (.*);

// File: tb/hpd_arbiter_test.sv
`timescale 1ns/1ps
module hpd_arbiter_test;

   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          en;
   logic          dp_hpd_in, tmds_hpd_in, cad_in, prio_tmds;
   logic          cad_invert, comp_mode, comp_dp_hpd, comp_src_hpd;
   logic [PW-1:0] swap_len;
   logic          src_hpd, cad_src, dp_tmds_mode;
   logic [1:0]    route;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   hpd_arbiter #(.SYNC_STAGES(2), .DEB_CYCLES(4), .PULSE_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .dp_hpd_in(dp_hpd_in), .tmds_hpd_in(tmds_hpd_in), .cad_in(cad_in),
      .prio_tmds(prio_tmds), .cad_invert(cad_invert), .comp_mode(comp_mode),
      .comp_dp_hpd(comp_dp_hpd), .comp_src_hpd(comp_src_hpd), .swap_len(swap_len),
      .src_hpd(src_hpd), .cad_src(cad_src), .route(route), .dp_tmds_mode(dp_tmds_mode)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_route(input logic dp, input logic tm, input logic pr);
      if (dp && tm) return pr ? 2'b10 : 2'b01;
      if (dp)       return 2'b01;
      if (tm)       return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic exp_cad(input logic [1:0] rt, input logic c, input logic inv);
      if (rt == 2'b01) return c ^ inv;
      return rt == 2'b10;
   endfunction

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Count low samples of src_hpd over a window; report route at first low
   task automatic watch_low(input int win, output int lows, output logic [1:0] first_rt);
      lows = 0;
      first_rt = 2'b00;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (!src_hpd) begin
            if (lows == 0) first_rt = route;
            lows++;
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int            lows;
      logic [1:0]    frt;
      logic          any_hi;
      void'($urandom(32'h5A17));
      rst_n = 1'b0; en = 1'b0;
      dp_hpd_in = 0; tmds_hpd_in = 0; cad_in = 0; prio_tmds = 0;
      cad_invert = 0; comp_mode = 0; comp_dp_hpd = 0; comp_src_hpd = 0;
      swap_len = 8'd5;
      ticks(3);
      chk("R4", "reset route", route, 2'b00);
      chk("R2", "reset src_hpd", src_hpd, 1'b0);
      chk("R7", "reset cad_src", cad_src, 1'b0);
      rst_n = 1'b1; en = 1'b1;
      ticks(3);

      // R1 exact latency: driven on a falling edge
      dp_hpd_in = 1'b1;
      repeat (6) @(posedge clk);
      @(negedge clk);
      chk("R1", "route after 6 edges", route, 2'b00);
      @(posedge clk);
      @(negedge clk);
      chk("R1", "route after 7 edges", route, 2'b01);
      chk("R2", "src_hpd with DP", src_hpd, 1'b1);
      chk("R8", "native DP flag", dp_tmds_mode, 1'b0);

      // R1 short glitch on the HDMI input is ignored
      tmds_hpd_in = 1'b1; prio_tmds = 1'b1;
      ticks(3);
      tmds_hpd_in = 1'b0;
      any_hi = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (route != 2'b01 || !src_hpd) any_hi = 1'b1;
      end
      chk("R1", "glitch disturbed selection", any_hi, 1'b0);

      // R3 / R5 / R6 priority switchover with pulse length 5
      prio_tmds = 1'b0; swap_len = 8'd5;
      ticks(20);
      tmds_hpd_in = 1'b1;
      ticks(20);
      chk("R3", "both present prio low", route, 2'b01);
      prio_tmds = 1'b1;
      watch_low(30, lows, frt);
      chk("R6", "swap pulse length 5", lows, 5);
      chk("R5", "route at pulse start", frt, 2'b10);
      chk("R3", "both present prio high", route, 2'b10);
      chk("R2", "src_hpd after swap", src_hpd, 1'b1);

      // R6 zero length gives one cycle
      swap_len = 8'd0;
      prio_tmds = 1'b0;
      watch_low(30, lows, frt);
      chk("R6", "swap pulse length 0", lows, 1);
      chk("R5", "route at pulse start back", frt, 2'b01);

      // R6 unplug of selected DP sink: no pulse
      swap_len = 8'd5;
      dp_hpd_in = 1'b0;
      watch_low(30, lows, frt);
      chk("R6", "unplug gives no pulse", lows, 0);
      chk("R4", "single HDMI sink", route, 2'b10);
      chk("R7", "cad_src with HDMI", cad_src, 1'b1);

      // R4 no sink
      tmds_hpd_in = 1'b0;
      ticks(20);
      chk("R4", "no sink route", route, 2'b00);
      chk("R2", "no sink src_hpd", src_hpd, 1'b0);

      // R7 / R8 CAD polarity and mode flag
      dp_hpd_in = 1'b1; cad_in = 1'b1;
      ticks(20);
      chk("R7", "cad follows input", cad_src, 1'b1);
      chk("R8", "dual-mode flag", dp_tmds_mode, 1'b1);
      cad_invert = 1'b1;
      @(negedge clk);
      chk("R7", "cad inverted", cad_src, 1'b0);

      // R9 disable
      en = 1'b0; comp_mode = 1'b1; comp_src_hpd = 1'b1;
      @(negedge clk);
      chk("R9", "disabled route", route, 2'b00);
      chk("R9", "disabled src_hpd", src_hpd, 1'b0);
      chk("R9", "disabled cad_src", cad_src, 1'b0);
      comp_mode = 1'b0; comp_src_hpd = 1'b0;
      ticks(10);
      en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R9", "route one edge after enable", route, 2'b01);
      chk("R9", "cad_invert back in force", cad_src, 1'b0);
      cad_invert = 1'b0;

      // R10 compliance override
      dp_hpd_in = 1'b0;
      ticks(20);
      comp_mode = 1'b1; comp_dp_hpd = 1'b1; comp_src_hpd = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "override selects DP", route, 2'b01);
      chk("R10", "src_hpd follows register", src_hpd, 1'b0);
      comp_src_hpd = 1'b1;
      #0.1;
      chk("R10", "src_hpd follows register high", src_hpd, 1'b1);
      comp_mode = 1'b0; comp_dp_hpd = 1'b0; comp_src_hpd = 1'b0;
      ticks(20);

      // Random patterns, each held long enough to settle
      for (int it = 0; it < 60; it++) begin
         logic d, t, p, c, v;
         logic [1:0] er;
         d = 1'($urandom); t = 1'($urandom); p = 1'($urandom);
         c = 1'($urandom); v = 1'($urandom);
         dp_hpd_in = d; tmds_hpd_in = t; prio_tmds = p; cad_in = c; cad_invert = v;
         swap_len = PW'(1 + ($urandom % 6));
         ticks(30);
         er = exp_route(d, t, p);
         chk((d && t) ? "R3" : "R4", "random route", route, er);
         chk("R2", "random src_hpd", src_hpd, er != 2'b00);
         chk("R7", "random cad_src", cad_src, exp_cad(er, c, v));
         chk("R8", "random mode flag", dp_tmds_mode, (er == 2'b01) && c);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule